// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply-Accumulate Engine

The engine builds one TM×TN output tile of a matrix product C = A·B, where the shared dimension is cut into SLICES slices of TK columns of A and TK rows of B. It clears its output tile, then waits for one A slice (TM×TK) and one B slice (TK×TN) to be offered together. It works through each pair one micro-step per cycle. A micro-step multiplies one BR×BS block of A by one BS×BT block of B and adds the result into one BR×BT block of C. When a pair is used up, it hands both input buffers back. After the last slice it shows the finished tile and holds it until the consumer lets it go. It then clears the tile and starts the next one.

Each input slice arrives as a flat bus that a producer fills, with a per-operand flag that says the bus holds valid data. The release pulses tell the producer that the bus may be refilled. The output tile is a register bank that the consumer reads in full while `c_ready` is high.

Top module: `tile_mac_engine`

## Requirements
- R1: After reset, and again one cycle after a finished tile is released, every element of `c_tile` is zero and `c_ready` is low.
- R2: A slice pair is taken only when `a_avail` and `b_avail` are both high. With only one of them high, the engine waits: no release pulse, and `c_tile` stays unchanged.
- R3: A pair offered while the engine is idle takes (TM/BR)·(TN/BT)·(TK/BS) micro-step cycles. `a_release` and `b_release` then pulse high together for exactly one cycle, and are first seen high STEPS+1 cycles after the flags were raised (9 with the default parameters).
- R4: `c_ready` stays low until the SLICES-th pair has been released, and rises in the cycle right after that release. `c_tile` then holds the sum over all slices of A_slice·B_slice. Element (i,j) sits at bits [(i·TN+j)·AW +: AW].
- R5: Input slices are in blocked order. A block (bi,bk) of BR×BS elements starts at element index (bi·(TK/BS)+bk)·BR·BS and is row-major inside the block. B block (bk,bj) of BS×BT elements starts at (bk·(TN/BT)+bj)·BS·BT and is row-major inside the block. Element e of a bus occupies bits [e·DW +: DW].
- R6: Elements are signed two's complement. Accumulators are AW = 2·DW + clog2(SLICES·TK) bits wide and wrap on overflow rather than saturate.
- R7: While `c_ready` is high and `c_release` is low, `c_tile` and `c_ready` hold their values and availability flags are ignored. `c_release` sampled high while `c_ready` is high ends the tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_avail | input | 1 | A slice bus holds valid data |
| a_tile | input | TM·TK·DW | A slice, blocked layout |
| b_avail | input | 1 | B slice bus holds valid data |
| b_tile | input | TK·TN·DW | B slice, blocked layout |
| a_release | output | 1 | A slice consumed, one-cycle pulse |
| b_release | output | 1 | B slice consumed, one-cycle pulse |
| c_ready | output | 1 | Finished tile is valid |
| c_release | input | 1 | Consumer is done with the tile |
| c_tile | output | TM·TN·AW | Output tile, row-major |

## Verification
An all-zero A operand separates a real product from stale accumulator contents. An identity-like A shows that B rows are routed through the blocked layout to the right output positions. The extreme operands (127·−128 and −128·−128 in every element) exercise sign handling and the full accumulator width over all SLICES·TK terms. Seeded pseudo-random and small mixed-sign operands catch block-index and slice-offset errors that symmetric data would hide. Flag-only stalls and long holds of a finished tile show that nothing is consumed or disturbed outside a valid handshake.

// File: rtl/tile_mac_engine.sv
module tile_mac_engine #(
  parameter int DW     = 8,
  parameter int TM     = 4,
  parameter int TK     = 4,
  parameter int TN     = 4,
  parameter int BR     = 2,
  parameter int BS     = 2,
  parameter int BT     = 2,
  parameter int SLICES = 2,
  parameter int AW     = 2*DW + $clog2(SLICES*TK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_avail,
  input  logic [TM*TK*DW-1:0]   a_tile,
  input  logic                  b_avail,
  input  logic [TK*TN*DW-1:0]   b_tile,
  output logic                  a_release,
  output logic                  b_release,
  output logic                  c_ready,
  input  logic                  c_release,
  output logic [TM*TN*AW-1:0]   c_tile
);
  localparam int MB    = TM / BR;
  localparam int KB    = TK / BS;
  localparam int NB    = TN / BT;
  localparam int STEPS = MB * NB * KB;
  localparam int SW    = $clog2(STEPS + 1);
  localparam int LW    = $clog2(SLICES + 1);

  typedef enum logic [2:0] {S_CLR, S_WAIT, S_MAC, S_REL, S_DONE} st_t;

  st_t                  st;
  logic [SW-1:0]        step;
  logic [LW-1:0]        slice;
  logic signed [AW-1:0] acc  [TM*TN];
  logic signed [DW-1:0] a_el [TM*TK];
  logic signed [DW-1:0] b_el [TK*TN];
  logic signed [AW-1:0] part [BR*BT];
  int bi, bj, bk;

  for (genvar g = 0; g < TM*TK; g++) begin : g_a
    assign a_el[g] = $signed(a_tile[g*DW +: DW]);
  end
  for (genvar g = 0; g < TK*TN; g++) begin : g_b
    assign b_el[g] = $signed(b_tile[g*DW +: DW]);
  end
  for (genvar g = 0; g < TM*TN; g++) begin : g_c
    assign c_tile[g*AW +: AW] = acc[g];
  end

  assign a_release = (st == S_REL);
  assign b_release = (st == S_REL);
  assign c_ready   = (st == S_DONE);

  always_comb begin
    bk = int'(step) % KB;
    bj = (int'(step) / KB) % NB;
    bi = int'(step) / (KB * NB);
    for (int i = 0; i < BR; i++) begin
      for (int j = 0; j < BT; j++) begin
        logic signed [AW-1:0] sum;
        sum = '0;
        for (int p = 0; p < BS; p++) begin
          sum = sum + AW'(a_el[(bi*KB + bk)*BR*BS + i*BS + p] *
                          b_el[(bk*NB + bj)*BS*BT + p*BT + j]);
        end
        part[i*BT + j] = sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_CLR;
      step  <= '0;
      slice <= '0;
      for (int e = 0; e < TM*TN; e++) acc[e] <= '0;
    end else begin
      case (st)
        S_CLR: begin
          for (int e = 0; e < TM*TN; e++) acc[e] <= '0;
          slice <= '0;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          if (a_avail && b_avail) begin
            step <= '0;
            st   <= S_MAC;
          end
        end
        S_MAC: begin
          for (int i = 0; i < BR; i++)
            for (int j = 0; j < BT; j++)
              acc[(bi*BR + i)*TN + bj*BT + j] <= acc[(bi*BR + i)*TN + bj*BT + j] + part[i*BT + j];
          if (step == SW'(STEPS - 1)) st <= S_REL;
          else step <= step + 1'b1;
        end
        S_REL: begin
          if (slice == LW'(SLICES - 1)) st <= S_DONE;
          else begin
            slice <= slice + 1'b1;
            st    <= S_WAIT;
          end
        end
        S_DONE: if (c_release) st <= S_CLR;
        default: st <= S_CLR;
      endcase
    end
  end
endmodule

// File: rtl/tile_mac_engine_chk.sv
module tile_mac_engine_chk #(
  parameter int SLICES = 2,
  parameter int CW     = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_release,
  input logic          b_release,
  input logic          c_ready,
  input logic          c_release,
  input logic [CW-1:0] c_tile
);
  int rel_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) rel_cnt <= 0;
    else if (a_release) rel_cnt <= rel_cnt + 1;
    else if (c_ready && c_release) rel_cnt <= 0;
  end

  a_r3_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    a_release |=> !a_release);

  a_r3_b_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    b_release |=> !b_release);

  a_r4_slice_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_ready) |-> rel_cnt == SLICES);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ready && !c_release) |=> (c_ready && $stable(c_tile)));

  a_r1_clear_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(c_ready) |=> (c_tile == '0));
endmodule

bind tile_mac_engine tile_mac_engine_chk #(.SLICES(SLICES), .CW(TM*TN*AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_release(a_release), .b_release(b_release),
  .c_ready(c_ready), .c_release(c_release), .c_tile(c_tile)
);

// File: tb/tile_mac_engine_test.sv
`timescale 1ns/1ps
module tile_mac_engine_test;
  localparam int DW = 8, TM = 4, TK = 4, TN = 4, BR = 2, BS = 2, BT = 2, SLICES = 2;
  localparam int KF = TK * SLICES;
  localparam int AW = 2*DW + $clog2(KF);
  localparam int KB = TK / BS, NB = TN / BT, MB = TM / BR;
  localparam int STEPS = MB * NB * KB;
  localparam int NPAT = 8;
  localparam int PATS [NPAT][3] = '{
    '{0, 3, 11}, '{5, 3, 21}, '{1, 2, 0}, '{2, 2, 0},
    '{3, 3, 5},  '{3, 3, 77}, '{4, 3, 9}, '{3, 4, 1234}
  };

  logic clk = 0, rst_n = 0;
  logic a_avail = 0, b_avail = 0, c_release = 0;
  logic [TM*TK*DW-1:0] a_tile = '0;
  logic [TK*TN*DW-1:0] b_tile = '0;
  logic a_release, b_release, c_ready;
  logic [TM*TN*AW-1:0] c_tile;

  int checks = 0, errors = 0;
  int am [TM][KF];
  int bm [KF][TN];

  always #2.5 clk = ~clk;

  tile_mac_engine #(.DW(DW), .TM(TM), .TK(TK), .TN(TN), .BR(BR), .BS(BS), .BT(BT),
                    .SLICES(SLICES)) uut (
    .clk(clk), .rst_n(rst_n), .a_avail(a_avail), .a_tile(a_tile), .b_avail(b_avail),
    .b_tile(b_tile), .a_release(a_release), .b_release(b_release), .c_ready(c_ready),
    .c_release(c_release), .c_tile(c_tile));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gen(int kind, int seed, int r, int c);
    int unsigned x;
    case (kind)
      0: return 0;
      1: return 127;
      2: return -128;
      3: begin
        x = 32'(seed) * 32'd1103515245 + 32'(r*64 + c) * 32'd2654435761 + 32'd12345;
        return int'((x >> 13) & 255) - 128;
      end
      4: return ((r + 2*c + seed) % 5) - 2;
      default: return (r == c) ? 1 : 0;
    endcase
  endfunction

  task automatic pack_slice(input int s);
    for (int bi = 0; bi < MB; bi++)
      for (int bk = 0; bk < KB; bk++)
        for (int i = 0; i < BR; i++)
          for (int p = 0; p < BS; p++)
            a_tile[((bi*KB + bk)*BR*BS + i*BS + p)*DW +: DW] = DW'(am[bi*BR + i][s*TK + bk*BS + p]);
    for (int bk = 0; bk < KB; bk++)
      for (int bj = 0; bj < NB; bj++)
        for (int p = 0; p < BS; p++)
          for (int j = 0; j < BT; j++)
            b_tile[((bk*NB + bj)*BS*BT + p*BT + j)*DW +: DW] = DW'(bm[s*TK + bk*BS + p][bj*BT + j]);
  endtask

  task automatic check_tile(input string req);
    int bad = 0;
    longint act_f = 0, exp_f = 0;
    for (int i = 0; i < TM; i++)
      for (int j = 0; j < TN; j++) begin
        longint sum = 0;
        logic [AW-1:0] e;
        logic [AW-1:0] a;
        for (int q = 0; q < KF; q++) sum += longint'(am[i][q]) * longint'(bm[q][j]);
        e = sum[AW-1:0];
        a = c_tile[(i*TN + j)*AW +: AW];
        if (a != e) begin
          if (bad == 0) begin act_f = longint'($signed(a)); exp_f = longint'($signed(e)); end
          bad++;
        end
      end
    check(bad == 0, req, "tile contents", act_f, exp_f);
  endtask

  task automatic run_tile(input int hold);
    logic [TM*TN*AW-1:0] snap;
    for (int s = 0; s < SLICES; s++) begin
      int lat = 0;
      pack_slice(s);
      @(negedge clk);
      a_avail = 1; b_avail = 1;
      do begin @(negedge clk); lat++; end while (!a_release && lat < 50);
      check(lat == STEPS + 1, "R3", "release latency", lat, STEPS + 1);
      check(b_release == 1'b1, "R3", "b_release with a_release", b_release, 1);
      a_avail = 0; b_avail = 0;
      @(negedge clk);
      check(a_release == 1'b0, "R3", "release pulse width", a_release, 0);
      if (s < SLICES - 1) check(c_ready == 1'b0, "R4", "c_ready before last slice", c_ready, 0);
      else check(c_ready == 1'b1, "R4", "c_ready after last slice", c_ready, 1);
    end
    check_tile("R4 R5 R6");
    snap = c_tile;
    if (hold > 0) begin
      a_avail = 1; b_avail = 1;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(c_ready && !a_release && c_tile == snap, "R7", "hold while not released",
              {c_ready, a_release}, 2);
      end
      a_avail = 0; b_avail = 0;
    end
    c_release = 1;
    @(negedge clk);
    c_release = 0;
    @(negedge clk);
    check(!c_ready && c_tile == '0, "R1", "cleared after release", c_ready, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!c_ready && !a_release && !b_release && c_tile == '0, "R1", "reset state", c_ready, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!c_ready && c_tile == '0, "R1", "idle after reset", c_ready, 0);

    for (int w = 0; w < 2; w++) begin
      a_avail = (w == 0); b_avail = (w == 1);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        check(!a_release && !b_release && c_tile == '0, "R2", "stall on one flag",
              {a_release, b_release}, 0);
      end
      a_avail = 0; b_avail = 0;
    end

    for (int t = 0; t < NPAT; t++) begin
      for (int i = 0; i < TM; i++)
        for (int q = 0; q < KF; q++) am[i][q] = gen(PATS[t][0], PATS[t][2], i, q);
      for (int q = 0; q < KF; q++)
        for (int j = 0; j < TN; j++) bm[q][j] = gen(PATS[t][1], PATS[t][2] + 3, q, j);
      run_tile((t % 3 == 1) ? 5 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule